// File: doc/BRIEF.md
# Word-Addressed Single-Cycle Processor Core

This block is a small single-cycle processor that runs a subset of a classic 32-bit load/store instruction set. It covers register-to-register arithmetic and logic, load word, store word and branch-on-equal. Every instruction completes in one clock cycle. The core holds a program counter, a 32-entry register file, an ALU behind its own operation decoder, and separate instruction and data memories.

Both memories are indexed by word, not by byte. Consecutive instructions therefore occupy consecutive addresses, the program counter steps by one, and branch displacements are counted in words. Main decode is an opcode-indexed table of 9-bit control words, so new opcodes are added by filling table entries rather than by adding gates.

In use, a testbench holds reset and loads both memories through dedicated load ports. It then releases reset and lets the core run for a counted number of clocks. Finally it inspects data memory through a combinational peek port.

Top module: `wcpu_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0. While reset is low, the core executes exactly one instruction per rising clock edge. Instructions are taken from word addresses 0, 1, 2, … in order unless a branch is taken.
- R2: Instruction fields: opcode bits 31:26, rs bits 25:21, rt bits 20:16, rd bits 15:11, function bits 5:0, immediate bits 15:0 (sign-extended). The control word for opcode i is table entry i. Its bits are: 8 destination-select, 7 immediate-operand, 6 load-to-register, 5 register-write, 4 memory-read, 3 memory-write, 2 branch, 1:0 ALU class. Opcode 0 gives 100100010, opcode 35 gives 011110000, opcode 43 gives 010001000, opcode 4 gives 000000101, and every other opcode gives all zeros.
- R3: For opcode 0, function codes select the ALU operation and write the result to register rd: 32 selects add (modulo 2^32), 34 subtract, 36 bitwise AND, 37 bitwise OR, and 42 signed set-on-less-than (1 or 0).
- R4: Opcode 35 (load) writes register rt with the data word at index (rs + sign-extended immediate) modulo the data-memory depth.
- R5: Opcode 43 (store) writes register rt to the data word at index (rs + sign-extended immediate) modulo the depth, and changes no register.
- R6: Opcode 4 (branch) compares rs with rt. When they are equal, the next program counter is PC + 1 + sign-extended immediate, modulo the instruction-memory depth. When they differ, it is PC + 1.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: An opcode outside {0, 4, 35, 43} writes no register and no memory, and advances the program counter by 1.
- R9: The program "load r1 from word 1, load r2 from word 2, add r3 = r1 + r2, store r3 to word 3" leaves the sum of words 1 and 2 in word 3 after four clocks.
- R10: The load ports write memory on a rising edge. The peek ports read memory combinationally. While reset is high, the core itself writes neither memory nor registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_we | input | 1 | Load strobe for instruction memory |
| ld_imem_addr | input | IMEM_AW | Instruction memory load word index |
| ld_imem_data | input | 32 | Instruction word to load |
| ld_dmem_we | input | 1 | Load strobe for data memory |
| ld_dmem_addr | input | DMEM_AW | Data memory load word index |
| ld_dmem_data | input | 32 | Data word to load |
| pk_imem_addr | input | IMEM_AW | Instruction memory peek index |
| pk_imem_data | output | 32 | Instruction word at the peek index |
| pk_dmem_addr | input | DMEM_AW | Data memory peek index |
| pk_dmem_data | output | 32 | Data word at the peek index |

## Verification
The properties assume two things about the inputs. The load ports are used only while reset is held. Branch displacements matter only in their low program-counter-width bits, which requires an instruction address width of at most 16. The bench writes both memories completely under reset, then releases reset for an exact number of clocks and asserts it again, so loader and core never write in the same cycle. Sweeps cover ALU operand pairs across every function code, base/offset combinations including address wrap, and branch offsets that are backward, zero and forward. They also run every unassigned opcode, and each result is predicted from instruction-level arithmetic.

// File: rtl/wcpu_pkg.sv
package wcpu_pkg;

    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int RAW   = $clog2(NREG);
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'd35;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    // bit 8 down to bit 0, most significant member first
    typedef struct packed {
        logic       dst_rd;
        logic       imm_opnd;
        logic       ld_to_reg;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       brn;
        logic [1:0] alu_cls;
    } ctrl_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_e;

    function automatic ctrl_t ctrl_word(input logic [OPC_W-1:0] op);
        ctrl_t c;
        case (op)
            OPC_RTYPE: c = 9'b100100010;
            OPC_LW:    c = 9'b011110000;
            OPC_SW:    c = 9'b010001000;
            OPC_BEQ:   c = 9'b000000101;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wcpu_ctrl_rom.sv
module wcpu_ctrl_rom
    import wcpu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);
    localparam int DEPTH = 1 << OPC_W;

    ctrl_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign rom[g] = ctrl_word(OPC_W'(g));
    end

    assign ctrl = rom[opcode];
endmodule

// File: rtl/wcpu_alu_ctrl.sv
module wcpu_alu_ctrl
    import wcpu_pkg::*;
(
    input  logic [1:0] alu_cls,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);
    always_comb begin
        fn = ALU_ADD;
        case (alu_cls)
            2'b00: fn = ALU_ADD;
            2'b01: fn = ALU_SUB;
            2'b10: begin
                case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_ADD;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/wcpu_alu.sv
module wcpu_alu
    import wcpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/wcpu_regfile.sv
module wcpu_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] rf_q [N];
    logic [W-1:0] rf_d [N];

    always_comb begin
        rf_d = rf_q;
        if (rst) begin
            for (int i = 0; i < N; i++) rf_d[i] = '0;
        end else if (we && (wa != '0)) begin
            rf_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        rf_q <= rf_d;
    end

    assign rd1 = (ra1 == '0) ? '0 : rf_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : rf_q[ra2];
endmodule

// File: rtl/wcpu_wmem.sv
module wcpu_wmem #(
    parameter int AW = 6,
    parameter int W  = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [W-1:0]  cpu_wdata,
    output logic [W-1:0]  cpu_rdata,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_wdata,
    input  logic [AW-1:0] pk_addr,
    output logic [W-1:0]  pk_rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (cpu_we) mem_d[cpu_addr] = cpu_wdata;
        if (ld_we)  mem_d[ld_addr]  = ld_wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign cpu_rdata = mem_q[cpu_addr];
    assign pk_rdata  = mem_q[pk_addr];
endmodule

// File: rtl/wcpu_core.sv
module wcpu_core
    import wcpu_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_imem_we,
    input  logic [IMEM_AW-1:0] ld_imem_addr,
    input  logic [31:0]        ld_imem_data,
    input  logic               ld_dmem_we,
    input  logic [DMEM_AW-1:0] ld_dmem_addr,
    input  logic [31:0]        ld_dmem_data,
    input  logic [IMEM_AW-1:0] pk_imem_addr,
    output logic [31:0]        pk_imem_data,
    input  logic [DMEM_AW-1:0] pk_dmem_addr,
    output logic [31:0]        pk_dmem_data
);
    typedef struct packed {
        logic [IMEM_AW-1:0] pc;
    } core_st_t;

    core_st_t st_q, st_d;

    logic [IMEM_AW-1:0] pc_q;
    logic [XLEN-1:0]    instr;
    logic [OPC_W-1:0]   opcode;
    logic [RAW-1:0]     rs_addr, rt_addr, rd_addr;
    logic [5:0]         funct;
    logic [15:0]        imm16;
    logic [XLEN-1:0]    imm_sx;
    ctrl_t              ctrl;
    alu_fn_e            alu_fn;
    logic [XLEN-1:0]    rs_data, rt_data;
    logic [XLEN-1:0]    alu_b, alu_y;
    logic               alu_zero;
    logic [XLEN-1:0]    dm_rdata;
    logic               cpu_dm_we;
    logic               rf_we;
    logic [RAW-1:0]     rf_waddr;
    logic [XLEN-1:0]    rf_wdata;
    logic               br_take;
    logic               unused_bits;

    assign pc_q = st_q.pc;

    // instruction store: the core only reads it
    wcpu_wmem #(.AW(IMEM_AW), .W(XLEN)) u_imem (
        .clk       (clk),
        .cpu_we    (1'b0),
        .cpu_addr  (pc_q),
        .cpu_wdata ('0),
        .cpu_rdata (instr),
        .ld_we     (ld_imem_we),
        .ld_addr   (ld_imem_addr),
        .ld_wdata  (ld_imem_data),
        .pk_addr   (pk_imem_addr),
        .pk_rdata  (pk_imem_data)
    );

    assign opcode  = instr[31:26];
    assign rs_addr = instr[25:21];
    assign rt_addr = instr[20:16];
    assign rd_addr = instr[15:11];
    assign funct   = instr[5:0];
    assign imm16   = instr[15:0];
    assign imm_sx  = {{(XLEN-16){imm16[15]}}, imm16};

    assign unused_bits = ^{instr[10:6], ctrl.mem_rd};

    wcpu_ctrl_rom u_ctrl (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    wcpu_alu_ctrl u_aluc (
        .alu_cls (ctrl.alu_cls),
        .funct   (funct),
        .fn      (alu_fn)
    );

    wcpu_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (rs_addr),
        .ra2 (rt_addr),
        .rd1 (rs_data),
        .rd2 (rt_data),
        .we  (rf_we),
        .wa  (rf_waddr),
        .wd  (rf_wdata)
    );

    assign alu_b = ctrl.imm_opnd ? imm_sx : rt_data;

    wcpu_alu #(.W(XLEN)) u_alu (
        .fn   (alu_fn),
        .a    (rs_data),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign cpu_dm_we = ctrl.mem_wr & ~rst;

    wcpu_wmem #(.AW(DMEM_AW), .W(XLEN)) u_dmem (
        .clk       (clk),
        .cpu_we    (cpu_dm_we),
        .cpu_addr  (alu_y[DMEM_AW-1:0]),
        .cpu_wdata (rt_data),
        .cpu_rdata (dm_rdata),
        .ld_we     (ld_dmem_we),
        .ld_addr   (ld_dmem_addr),
        .ld_wdata  (ld_dmem_data),
        .pk_addr   (pk_dmem_addr),
        .pk_rdata  (pk_dmem_data)
    );

    assign rf_we    = ctrl.reg_wr & ~rst;
    assign rf_waddr = ctrl.dst_rd ? rd_addr : rt_addr;
    assign rf_wdata = ctrl.ld_to_reg ? dm_rdata : alu_y;
    assign br_take  = ctrl.brn & alu_zero;

    always_comb begin
        logic [IMEM_AW-1:0] pc_inc;
        st_d   = st_q;
        pc_inc = st_q.pc + IMEM_AW'(1);
        if (rst) begin
            st_d.pc = '0;
        end else if (br_take) begin
            st_d.pc = pc_inc + imm_sx[IMEM_AW-1:0];
        end else begin
            st_d.pc = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/wcpu_chk.sv
module wcpu_chk #(
    parameter int IAW = 6
) (
    input logic           clk,
    input logic           rst,
    input logic [IAW-1:0] pc_q,
    input logic [5:0]     opcode,
    input logic [15:0]    imm16,
    input logic           br_take,
    input logic           rf_we,
    input logic           dm_we,
    input logic [4:0]     rs_addr,
    input logic [31:0]    rs_data
);
    AST_PC_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc_q == '0);                                        // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !br_take |=> pc_q == $past(pc_q) + IAW'(1));                       // R1

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        br_take |=> pc_q == $past(pc_q) + IAW'(1) + $past(imm16[IAW-1:0])); // R6

    AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !rf_we);                                                 // R5

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        rs_addr == 5'd0 |-> rs_data == 32'd0);                             // R7

    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(opcode inside {6'd0, 6'd4, 6'd35, 6'd43}) |-> !rf_we && !dm_we && !br_take); // R8

    always @(posedge clk) begin
        if (rst) begin
            AST_RESET_QUIET: assert (!dm_we && !rf_we);                    // R10
        end
    end
endmodule

bind wcpu_core wcpu_chk #(.IAW(IMEM_AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_q    (pc_q),
    .opcode  (opcode),
    .imm16   (imm16),
    .br_take (br_take),
    .rf_we   (rf_we),
    .dm_we   (cpu_dm_we),
    .rs_addr (rs_addr),
    .rs_data (rs_data)
);

// File: tb/wcpu_core_bench.sv
`timescale 1ns/1ps
module wcpu_core_bench;
    localparam int IAW = 6;
    localparam int DAW = 6;
    localparam int DEPTH = 1 << IAW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_imem_we = 1'b0;
    logic [IAW-1:0] ld_imem_addr = '0;
    logic [31:0]    ld_imem_data = '0;
    logic           ld_dmem_we = 1'b0;
    logic [DAW-1:0] ld_dmem_addr = '0;
    logic [31:0]    ld_dmem_data = '0;
    logic [IAW-1:0] pk_imem_addr = '0;
    logic [31:0]    pk_imem_data;
    logic [DAW-1:0] pk_dmem_addr = '0;
    logic [31:0]    pk_dmem_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] prog [DEPTH];
    logic [31:0] dat  [DEPTH];

    always #2 clk = ~clk;

    wcpu_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_wcpu_core (
        .clk          (clk),
        .rst          (rst),
        .ld_imem_we   (ld_imem_we),
        .ld_imem_addr (ld_imem_addr),
        .ld_imem_data (ld_imem_data),
        .ld_dmem_we   (ld_dmem_we),
        .ld_dmem_addr (ld_dmem_addr),
        .ld_dmem_data (ld_dmem_data),
        .pk_imem_addr (pk_imem_addr),
        .pk_imem_data (pk_imem_data),
        .pk_dmem_addr (pk_dmem_addr),
        .pk_dmem_data (pk_dmem_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL WATCHDOG got %0d cycles exp fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] alu_ref(input int fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            32: return a + b;
            34: return a - b;
            36: return a & b;
            37: return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic clear_all();
        for (int i = 0; i < DEPTH; i++) begin
            prog[i] = '0;
            dat[i]  = '0;
        end
    endtask

    // writes both memories while reset is held
    task automatic load_all();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b1; ld_imem_addr = IAW'(i); ld_imem_data = prog[i];
            ld_dmem_we = 1'b1; ld_dmem_addr = DAW'(i); ld_dmem_data = dat[i];
        end
        @(negedge clk);
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        rst = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
    endtask

    task automatic peek(input int a, output logic [31:0] v);
        pk_dmem_addr = DAW'(a);
        #0.5;
        v = pk_dmem_data;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] vals [8];
        int fns [5];

        vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'd5, 32'd12345, 32'hFFFF_0000};
        fns = '{32, 34, 36, 37, 42};

        // R10: loader writes, peek reads, nothing executes under reset
        clear_all();
        prog[0] = enc_i(43, 0, 1, 9);
        dat[9]  = 32'h0000_1234;
        dat[17] = 32'hCAFE_0017;
        load_all();
        repeat (5) @(negedge clk);
        peek(9, v);  chk("R10 reset hold keeps word 9", v, 32'h0000_1234);
        peek(17, v); chk("R10 load readback word 17", v, 32'hCAFE_0017);
        pk_imem_addr = '0; #0.5;
        chk("R10 imem readback", pk_imem_data, enc_i(43, 0, 1, 9));

        // R9: four-instruction sum program
        for (int k = 0; k < 4; k++) begin
            clear_all();
            prog[0] = enc_i(35, 0, 1, 1);
            prog[1] = enc_i(35, 0, 2, 2);
            prog[2] = enc_r(1, 2, 3, 32);
            prog[3] = enc_i(43, 0, 3, 3);
            dat[1] = vals[k*2];
            dat[2] = vals[k*2+1] + 32'd77;
            load_all();
            run(4);
            peek(3, v);
            chk("R9 sum program", v, dat[1] + dat[2]);
        end

        // R3 / R2: every function code over all operand pairs
        foreach (fns[f]) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    clear_all();
                    prog[0] = enc_i(35, 0, 1, 0);
                    prog[1] = enc_i(35, 0, 2, 1);
                    prog[2] = enc_r(1, 2, 3, fns[f]);
                    prog[3] = enc_i(43, 0, 3, 2);
                    dat[0] = vals[i];
                    dat[1] = vals[j];
                    dat[2] = 32'hDEAD_BEEF;
                    load_all();
                    run(4);
                    peek(2, v);
                    chk($sformatf("R3 fn %0d", fns[f]), v, alu_ref(fns[f], vals[i], vals[j]));
                end
            end
        end

        // R1: exact instruction count and order after reset
        for (int n = 0; n < 10; n++) begin
            clear_all();
            prog[0] = enc_i(35, 0, 1, 0);
            for (int s = 0; s < 4; s++) begin
                prog[1+2*s] = enc_r(2, 1, 2, 32);
                prog[2+2*s] = enc_i(43, 0, 2, 10 + s);
            end
            dat[0] = 32'd3;
            load_all();
            run(n);
            for (int s = 0; s < 4; s++) begin
                peek(10 + s, v);
                chk($sformatf("R1 order n=%0d slot %0d", n, s), v,
                    (n >= 3 + 2*s) ? 32'(3 * (s + 1)) : 32'd0);
            end
        end

        // R4: load with base plus signed offset, wrapping the index
        begin
            int bases [4];
            int offs [5];
            bases = '{4, 20, 40, 62};
            offs  = '{-3, -1, 0, 1, 5};
            foreach (bases[b]) begin
                foreach (offs[o]) begin
                    int ea;
                    clear_all();
                    for (int i = 1; i < DEPTH; i++) dat[i] = 32'(1000 + i);
                    dat[0] = 32'(bases[b]);
                    prog[0] = enc_i(35, 0, 1, 0);
                    prog[1] = enc_i(35, 1, 2, offs[o]);
                    prog[2] = enc_i(43, 0, 2, 60);
                    load_all();
                    run(3);
                    ea = (bases[b] + offs[o]) & (DEPTH - 1);
                    peek(60, v);
                    chk($sformatf("R4 base %0d off %0d", bases[b], offs[o]), v, 32'(1000 + ea));
                end
            end
        end

        // R5: store with offset, and the store leaves registers alone
        clear_all();
        dat[0] = 32'd500;
        prog[0] = enc_i(35, 0, 1, 0);
        prog[1] = enc_i(43, 1, 1, -493);
        prog[2] = enc_i(43, 0, 1, 8);
        load_all();
        run(3);
        peek(7, v); chk("R5 store to base+offset", v, 32'd500);
        peek(8, v); chk("R5 store kept source register", v, 32'd500);

        // R7: register 0 ignores load and ALU writes
        clear_all();
        dat[0] = 32'd77;
        dat[5] = 32'd99;
        prog[0] = enc_i(35, 0, 0, 0);
        prog[1] = enc_i(35, 0, 1, 0);
        prog[2] = enc_r(1, 1, 0, 32);
        prog[3] = enc_i(43, 0, 0, 5);
        prog[4] = enc_i(43, 0, 1, 6);
        load_all();
        run(5);
        peek(5, v); chk("R7 r0 still zero", v, 32'd0);
        peek(6, v); chk("R7 r1 loaded", v, 32'd77);

        // R6: branch equal/unequal with backward, zero and forward offsets
        begin
            logic [31:0] pa [3];
            logic [31:0] pb [3];
            pa = '{32'd9, 32'd9, 32'd9};
            pb = '{32'd9, 32'd10, 32'hFFFF_FFF7};
            for (int c = 0; c < 3; c++) begin
                for (int o = -1; o <= 6; o++) begin
                    logic taken;
                    clear_all();
                    dat[0] = pa[c];
                    dat[1] = pb[c];
                    prog[0] = enc_i(35, 0, 1, 0);
                    prog[1] = enc_i(35, 0, 2, 1);
                    prog[2] = enc_i(4, 1, 2, o);
                    for (int a = 3; a <= 12; a++) prog[a] = enc_i(43, 0, 1, 20 + a);
                    load_all();
                    run(13);
                    taken = (pa[c] == pb[c]);
                    for (int a = 3; a <= 12; a++) begin
                        logic [31:0] e;
                        if (!taken)          e = pa[c];
                        else if (o < 0)      e = 32'd0;
                        else if (a >= 3 + o) e = pa[c];
                        else                 e = 32'd0;
                        peek(20 + a, v);
                        chk($sformatf("R6 case %0d off %0d slot %0d", c, o, a), v, e);
                    end
                end
            end
        end

        // R8 / R2: every unassigned opcode is inert
        for (int op = 0; op < 64; op++) begin
            if (op == 0 || op == 4 || op == 35 || op == 43) continue;
            clear_all();
            dat[0] = 32'd321;
            dat[5] = 32'd555;
            prog[0] = enc_i(35, 0, 1, 0);
            prog[1] = enc_i(op, 0, 1, 5);
            prog[2] = enc_i(43, 0, 1, 2);
            load_all();
            run(3);
            peek(2, v); chk($sformatf("R8 op %0d keeps register", op), v, 32'd321);
            peek(5, v); chk($sformatf("R8 op %0d keeps memory", op), v, 32'd555);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule